// File: doc/BRIEF.md
# Chained-Descriptor Memory Copy Channel

This block is a single memory-to-memory transfer channel that takes its work orders from memory. Software writes the address of a first work order (a descriptor of six 32-bit words) and sets the enable bit. The channel then reads the descriptor, moves the described number of bytes one beat at a time from the source side to the destination side, and raises a one-cycle completion event. It then follows the descriptor's link word to the next descriptor until the link holds the end-of-chain value 0xFFFFF800. At that point it clears its own enable bit and goes idle.

Each side (source and destination) has its own element width and its own address behaviour: it either walks forward in memory or stays on a fixed device address. Beats are grouped into bursts of 1, 4, 8 or 16. The channel can insert a programmable number of idle cycles after every burst. When either side is a fixed device address, each burst waits for a peripheral request. Every beat moves one bus word. The element width only sets the address step and how many bytes the beat takes off the remaining count.

The control is one state machine with these states:
- IDLE: waits for the enable bit.
- FETCH: reads the six descriptor words.
- ISSUE: decides whether a beat may start.
- READ: performs the source read.
- WRITE: performs the destination write.
- GAP: counts the wait cycles after a burst.
- END: pulses the event and follows the link.

Transitions:
- IDLE→FETCH when the channel is enabled.
- FETCH→ISSUE after the sixth word, or FETCH→IDLE if the channel is halted.
- ISSUE→READ when a beat may start.
- ISSUE→END when no bytes remain.
- ISSUE→IDLE when halted.
- ISSUE stays in ISSUE while paused or while a burst waits for its peripheral request.
- READ→WRITE on the read response.
- WRITE→GAP at the end of a burst when the wait count is non-zero.
- WRITE→ISSUE otherwise.
- WRITE→IDLE when halted.
- GAP→ISSUE when the count runs out, or GAP→IDLE when halted.
- END→FETCH on a link.
- END→IDLE on the end-of-chain value or when halted.

Top module: `ldma_channel`

## Requirements
- R1: After reset the channel is in IDLE, every register reads 0 and `mem_req` is low.
- R2: Register word offsets, selected by `reg_off[4:2]` with `reg_off[1:0]` zero, are:
  - 0x00: enable, bit 0.
  - 0x04: pause, bit 0.
  - 0x08: descriptor start address; the low two bits always read 0.
  - 0x0C: config.
  - 0x10: current source.
  - 0x14: current destination.
  - 0x18: bytes left.
  - 0x1C: parameter.

  Writes to offsets 0x0C through 0x1C are ignored, and those registers show the values loaded from descriptors and live progress.
- R3: Once enabled, the channel reads six words at start, start+4 … start+20, in the order config, source, destination, byte count, parameter, link.
- R4: Config field positions:

  | Side | Width code | Burst code | Address mode | Request type |
  |---|---|---|---|---|
  | Destination | bits 26:25 | bits 23:22 | bit 21 | bits 20:16 |
  | Source | bits 10:9 | bits 7:6 | bit 5 | bits 4:0 |

  Width codes 0/1/2/3 mean 1/2/4/8 bytes. Each beat takes min(source width bytes, bytes left) off the bytes-left count.
- R5: With address mode 0 a side's address advances by its own width in bytes after every beat. With mode 1 it stays fixed.
- R6: Beats are grouped into bursts by the source burst code (0/1/2/3 → 1/4/8/16 beats). When either side's address mode is 1, each burst starts only while `periph_req` is high.
- R7: After every completed burst the channel stays idle for exactly parameter[7:0] cycles.
- R8: When bytes left is zero, `pkg_end` pulses for one cycle. The channel then fetches the descriptor at the link address, or, if the link is 0xFFFFF800, clears enable and returns to IDLE. A byte count of 0 gives the pulse with no beats.
- R9: While pause is 1 no new beat starts. After pause is cleared the transfer continues from the current addresses and count and completes correctly.
- R10: Writing 0 to enable halts the channel after the memory access in flight. No further requests follow, and enable reads 0.
- R11: Each beat reads the current source address and then writes the returned word to the current destination address. A request keeps its address, data and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_off | input | 5 | Register byte offset within the channel |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_off` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Memory read data |
| periph_req | input | 1 | Peripheral request that gates each burst |
| pkg_end | output | 1 | One-cycle pulse when a descriptor's byte count is exhausted |

## Verification
The bench sweeps every source width, destination width and burst length with a byte count that does not divide evenly. A design that subtracted the full width on the last beat, or stepped both sides by one width, would write the wrong number of words or to the wrong addresses. Each case is run with and without wait cycles, and the run-time difference must equal the wait count times the number of bursts. A gap missing after the final burst, or a gap counted once too often, shows up as a wrong difference.

Fixed-address runs release exactly one burst per request pulse, which catches a gate that is checked per beat instead of per burst. Pause, halt, a two-descriptor chain and a zero-byte descriptor expose several faults:
- beats leaking past pause or halt;
- a lost link;
- a missing or doubled completion event.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_READ,
        ST_WRITE,
        ST_GAP,
        ST_END
    } ldma_state_e;

    // register word indices (byte offset / 4)
    localparam logic [2:0] RI_ENABLE = 3'd0;
    localparam logic [2:0] RI_PAUSE  = 3'd1;
    localparam logic [2:0] RI_START  = 3'd2;
    localparam logic [2:0] RI_CFG    = 3'd3;
    localparam logic [2:0] RI_SRC    = 3'd4;
    localparam logic [2:0] RI_DST    = 3'd5;
    localparam logic [2:0] RI_LEFT   = 3'd6;
    localparam logic [2:0] RI_PARAM  = 3'd7;

    // descriptor word indices
    localparam logic [2:0] DW_CFG   = 3'd0;
    localparam logic [2:0] DW_SRC   = 3'd1;
    localparam logic [2:0] DW_DST   = 3'd2;
    localparam logic [2:0] DW_COUNT = 3'd3;
    localparam logic [2:0] DW_PARAM = 3'd4;
    localparam logic [2:0] DW_LINK  = 3'd5;

    // element width code -> bytes per beat
    function automatic logic [3:0] width_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // burst code -> beats per burst
    function automatic logic [4:0] burst_beats(input logic [1:0] code);
        return (code == 2'd0) ? 5'd1 : (5'd2 << code);
    endfunction

endpackage

// File: rtl/ldma_side_step.sv
module ldma_side_step #(
    parameter int AW = 32
) (
    input  logic [1:0]    width_code,
    input  logic          fixed_mode,
    input  logic [AW-1:0] cur_addr,
    output logic [AW-1:0] next_addr,
    output logic [3:0]    step_bytes
);
    import ldma_pkg::*;

    always_comb begin
        step_bytes = width_bytes(width_code);
        next_addr  = fixed_mode ? cur_addr : cur_addr + AW'(step_bytes);
    end

endmodule

// File: rtl/ldma_gap_timer.sv
module ldma_gap_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CW'(1));

    // R7: a gap is only ever armed with a non-zero length
    a_r7_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> load_val != '0);

    // R7: while counting, the count falls by exactly one per tick
    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/ldma_channel.sv
module ldma_channel #(
    parameter int          AW       = 32,
    parameter int          WAIT_W   = 8,
    parameter logic [31:0] LINK_END = 32'hFFFF_F800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_off,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic          periph_req,
    output logic          pkg_end
);
    import ldma_pkg::*;

    localparam int NSIDE   = 2;
    localparam int SIDE_SH = 16;   // destination fields sit 16 bits above source fields
    localparam int NWORDS  = 6;

    ldma_state_e st, nx;

    logic          en_q, pause_q;
    logic [31:0]   start_q, cfg_q, para_q, link_q, bcnt_q, data_q;
    logic [AW-1:0] src_q, dst_q, ptr_q;
    logic [2:0]    widx_q;
    logic [4:0]    beat_q;

    logic          reg_hit;
    logic [2:0]    reg_idx;
    logic [AW-1:0] side_cur  [NSIDE];
    logic [AW-1:0] side_next [NSIDE];
    logic [3:0]    side_step [NSIDE];

    logic          need_drq, burst_done, gap_load, gap_last, link_is_end;
    logic [4:0]    beats_per_burst;
    logic [31:0]   dec_bytes, bcnt_after;

    assign reg_hit = (reg_off[1:0] == 2'b00);
    assign reg_idx = reg_off[4:2];

    assign side_cur[0] = src_q;
    assign side_cur[1] = dst_q;

    // per-side address stepping, one instance per side
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        ldma_side_step #(.AW(AW)) u_step (
            .width_code (cfg_q[g*SIDE_SH + 10 : g*SIDE_SH + 9]),
            .fixed_mode (cfg_q[g*SIDE_SH + 5]),
            .cur_addr   (side_cur[g]),
            .next_addr  (side_next[g]),
            .step_bytes (side_step[g])
        );
    end

    assign need_drq        = cfg_q[5] | cfg_q[SIDE_SH + 5];
    assign beats_per_burst = burst_beats(cfg_q[7:6]);
    assign dec_bytes       = (bcnt_q < 32'(side_step[0])) ? bcnt_q : 32'(side_step[0]);
    assign bcnt_after      = bcnt_q - dec_bytes;
    assign burst_done      = (beat_q == beats_per_burst - 5'd1) || (bcnt_after == 32'd0);
    assign gap_load        = (st == ST_WRITE) && mem_ack && burst_done && (para_q[WAIT_W-1:0] != '0);
    assign link_is_end     = (link_q == LINK_END);

    ldma_gap_timer #(.CW(WAIT_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (para_q[WAIT_W-1:0]),
        .tick     (st == ST_GAP),
        .last     (gap_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    // next state
    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE:  if (en_q) nx = ST_FETCH;
            ST_FETCH: if (mem_ack) begin
                          if (!en_q)                             nx = ST_IDLE;
                          else if (widx_q == 3'(NWORDS - 1))     nx = ST_ISSUE;
                      end
            ST_ISSUE: begin
                          if (!en_q)                              nx = ST_IDLE;
                          else if (bcnt_q == 32'd0)               nx = ST_END;
                          else if (pause_q)                       nx = ST_ISSUE;
                          else if (beat_q == 5'd0 && need_drq && !periph_req) nx = ST_ISSUE;
                          else                                    nx = ST_READ;
                      end
            ST_READ:  if (mem_ack) nx = ST_WRITE;
            ST_WRITE: if (mem_ack) begin
                          if (!en_q)         nx = ST_IDLE;
                          else if (gap_load) nx = ST_GAP;
                          else               nx = ST_ISSUE;
                      end
            ST_GAP:   begin
                          if (!en_q)         nx = ST_IDLE;
                          else if (gap_last) nx = ST_ISSUE;
                      end
            ST_END:   nx = (link_is_end || !en_q) ? ST_IDLE : ST_FETCH;
            default:  nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = data_q;
        pkg_end   = 1'b0;
        unique case (st)
            ST_FETCH: begin mem_req = 1'b1; mem_addr = ptr_q + AW'({widx_q, 2'b00}); end
            ST_READ:  begin mem_req = 1'b1; mem_addr = src_q; end
            ST_WRITE: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst_q; end
            ST_END:   pkg_end = 1'b1;
            default:  ;
        endcase
    end

    // datapath and registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;  pause_q <= 1'b0;
            start_q <= '0; cfg_q <= '0; para_q <= '0; link_q <= '0;
            bcnt_q <= '0;  data_q <= '0;
            src_q <= '0;   dst_q <= '0; ptr_q <= '0;
            widx_q <= '0;  beat_q <= '0;
        end else begin
            if (st == ST_IDLE && en_q) begin
                ptr_q  <= start_q;
                widx_q <= '0;
            end
            if (st == ST_FETCH && mem_ack) begin
                unique case (widx_q)
                    DW_CFG:   cfg_q  <= mem_rdata;
                    DW_SRC:   src_q  <= mem_rdata;
                    DW_DST:   dst_q  <= mem_rdata;
                    DW_COUNT: bcnt_q <= mem_rdata;
                    DW_PARAM: para_q <= mem_rdata;
                    DW_LINK:  link_q <= mem_rdata;
                    default:  ;
                endcase
                widx_q <= (widx_q == 3'(NWORDS - 1)) ? 3'd0 : widx_q + 3'd1;
                beat_q <= '0;
            end
            if (st == ST_READ && mem_ack)
                data_q <= mem_rdata;
            if (st == ST_WRITE && mem_ack) begin
                src_q  <= side_next[0];
                dst_q  <= side_next[1];
                bcnt_q <= bcnt_after;
                beat_q <= burst_done ? 5'd0 : beat_q + 5'd1;
            end
            if (st == ST_END) begin
                if (link_is_end) en_q <= 1'b0;
                ptr_q  <= link_q;
                widx_q <= '0;
            end
            // software writes take priority over the terminator clear
            if (reg_we && reg_hit) begin
                unique case (reg_idx)
                    RI_ENABLE: en_q    <= reg_wdata[0];
                    RI_PAUSE:  pause_q <= reg_wdata[0];
                    RI_START:  start_q <= reg_wdata & 32'hFFFF_FFFC;
                    default:   ;
                endcase
            end
        end
    end

    // register read
    always_comb begin
        reg_rdata = '0;
        if (reg_hit) begin
            unique case (reg_idx)
                RI_ENABLE: reg_rdata = {31'd0, en_q};
                RI_PAUSE:  reg_rdata = {31'd0, pause_q};
                RI_START:  reg_rdata = start_q;
                RI_CFG:    reg_rdata = cfg_q;
                RI_SRC:    reg_rdata = 32'(src_q);
                RI_DST:    reg_rdata = 32'(dst_q);
                RI_LEFT:   reg_rdata = bcnt_q;
                RI_PARAM:  reg_rdata = para_q;
                default:   reg_rdata = '0;
            endcase
        end
    end

    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !mem_req);

    // R11: a request holds its address and direction until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8: completion event lasts a single cycle
    a_r8_pkg_single: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_end |=> !pkg_end);

    // R4: bytes left never grows except from a descriptor load
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_FETCH) |=> bcnt_q <= $past(bcnt_q));

    // R9: pause prevents a new beat
    a_r9_pause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ISSUE && pause_q) |=> st != ST_READ);

    // R6: a burst on a fixed side waits for the peripheral request
    a_r6_drq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ISSUE && beat_q == 5'd0 && need_drq && !periph_req) |=> st != ST_READ);

    // R5: a fixed source address does not move across a beat
    a_r5_fixed_src: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE && mem_ack && cfg_q[5]) |=> src_q == $past(src_q));

    // R10: a halted channel goes idle from the decision state
    a_r10_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ISSUE && !en_q) |=> st == ST_IDLE);

endmodule

// File: tb/ldma_channel_tb.sv
module ldma_channel_tb;

    localparam logic [31:0] TERM = 32'hFFFF_F800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        periph_req = 1'b0;
    logic        pkg_end;

    always #2 clk = ~clk;   // 250 MHz

    ldma_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .periph_req(periph_req),
        .pkg_end(pkg_end)
    );

    // memory model
    logic [31:0] mem [bit [31:0]];
    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction
    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : pat(a);
    endfunction

    logic        log_clr = 1'b0;
    int          wr_n, rd_n, pk_n, cyc;
    logic [31:0] wr_addr [64];
    logic [31:0] wr_data [64];
    logic [31:0] rd_addr [64];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= rdm(mem_addr);
        end
        if (log_clr) begin
            wr_n <= 0; rd_n <= 0; pk_n <= 0;
        end else begin
            if (mem_req && mem_ack && mem_we && wr_n < 64) begin
                wr_addr[wr_n] <= mem_addr; wr_data[wr_n] <= mem_wdata; wr_n <= wr_n + 1;
            end
            if (mem_req && mem_ack && !mem_we && rd_n < 64) begin
                rd_addr[rd_n] <= mem_addr; rd_n <= rd_n + 1;
            end
            if (pkg_end) pk_n <= pk_n + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit timeout = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] off, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_off = off; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] off, output logic [31:0] d);
        @(negedge clk); reg_off = off; #1 d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] b, input logic [31:0] c, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] n, input logic [31:0] p,
                            input logic [31:0] lk);
        mem[b] = c; mem[b+4] = s; mem[b+8] = d; mem[b+12] = n; mem[b+16] = p; mem[b+20] = lk;
    endtask

    function automatic logic [31:0] mkcfg(input int sw, input int sb, input int sm,
                                          input int dw, input int db, input int dm);
        return (32'(dw) << 25) | (32'(db) << 22) | (32'(dm) << 21) |
               (32'(sw) << 9)  | (32'(sb) << 6)  | (32'(sm) << 5);
    endfunction

    task automatic clear_logs();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic start_run(input logic [31:0] start);
        clear_logs();
        reg_write(5'h08, start);
        reg_write(5'h00, 32'd1);
    endtask

    task automatic wait_idle(output int dur);
        logic [31:0] v;
        int t0 = cyc;
        for (int k = 0; k < 5000; k++) begin
            reg_read(5'h00, v);
            if (v[0] == 1'b0) break;
        end
        dur = cyc - t0;
    endtask

    // checks the write log against an arithmetic model of one descriptor
    task automatic chk_writes(input int first, input int beats, input logic [31:0] s, input int ss,
                              input logic [31:0] d, input int ds, input string tag);
        int bad = 0;
        logic [31:0] ea = '0, ed = '0;
        for (int i = 0; i < beats; i++) begin
            ea = d + 32'(i * ds);
            ed = pat(s + 32'(i * ss));
            if (wr_addr[first+i] !== ea || wr_data[first+i] !== ed) bad++;
        end
        chk(bad == 0, tag, 32'(bad), 32'd0);
    endtask

    task automatic main();
        logic [31:0] v, v2;
        int dur0, dur1, snap;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reg_read(5'h00, v);  chk(v == 0, "R1 enable after reset", v, 0);
        reg_read(5'h18, v);  chk(v == 0, "R1 bytes left after reset", v, 0);
        reg_read(5'h0C, v);  chk(v == 0, "R1 config after reset", v, 0);
        chk(mem_req == 0, "R1 no request after reset", 32'(mem_req), 0);

        // R2: register map behaviour
        reg_write(5'h08, 32'h0000_0407);
        reg_read(5'h08, v);  chk(v == 32'h404, "R2 start address alignment", v, 32'h404);
        reg_write(5'h10, 32'hDEAD_BEEF);
        reg_read(5'h10, v);  chk(v == 0, "R2 write to current source ignored", v, 0);
        reg_write(5'h18, 32'h1234);
        reg_read(5'h18, v);  chk(v == 0, "R2 write to bytes left ignored", v, 0);
        reg_write(5'h04, 32'd1);
        reg_read(5'h04, v);  chk(v == 1, "R2 pause readback", v, 1);
        reg_write(5'h04, 32'd0);

        // R3 R4 R5 R6 R7: sweep of widths and bursts, linear sides, with and without gaps
        for (int sw = 0; sw < 4; sw++)
            for (int dw = 0; dw < 4; dw++)
                for (int bl = 0; bl < 4; bl++) begin
                    int ss = 1 << sw, ds = 1 << dw;
                    int beats = (20 + ss - 1) / ss;
                    int blen = (bl == 0) ? 1 : (2 << bl);
                    int bursts = (beats + blen - 1) / blen;
                    logic [31:0] c = mkcfg(sw, bl, 0, dw, 0, 0);
                    put_desc(32'h400, c, 32'h1000, 32'h8000, 20, 0, TERM);
                    start_run(32'h400);
                    wait_idle(dur0);
                    if (sw == 0 && dw == 0 && bl == 0) begin
                        int bad = 0;
                        for (int i = 0; i < 6; i++)
                            if (rd_addr[i] !== 32'h400 + 32'(4*i)) bad++;
                        chk(bad == 0, "R3 descriptor fetch addresses", 32'(bad), 0);
                    end
                    chk(wr_n == beats, "R4 beat count", 32'(wr_n), 32'(beats));
                    chk_writes(0, beats, 32'h1000, ss, 32'h8000, ds, "R11 R5 beat addresses and data");
                    chk(pk_n == 1, "R8 single completion", 32'(pk_n), 1);
                    reg_read(5'h18, v);  chk(v == 0, "R4 bytes left zero", v, 0);
                    reg_read(5'h10, v);
                    chk(v == 32'h1000 + 32'(beats*ss), "R5 final source", v, 32'h1000 + 32'(beats*ss));
                    reg_read(5'h14, v);
                    chk(v == 32'h8000 + 32'(beats*ds), "R5 final destination", v, 32'h8000 + 32'(beats*ds));
                    reg_read(5'h0C, v);  chk(v == c, "R2 config readback", v, c);
                    put_desc(32'h400, c, 32'h1000, 32'h8000, 20, 3, TERM);
                    start_run(32'h400);
                    wait_idle(dur1);
                    chk(dur1 - dur0 == 3 * bursts, "R7 R6 gap cycles per burst",
                        32'(dur1 - dur0), 32'(3 * bursts));
                end

        // R6 R5: fixed destination, one burst of 4 per request pulse
        put_desc(32'h500, mkcfg(2, 1, 0, 2, 1, 1), 32'h2000, 32'h9000, 32, 0, TERM);
        start_run(32'h500);
        repeat (60) @(negedge clk);
        chk(wr_n == 0, "R6 no beats without request", 32'(wr_n), 0);
        periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
        repeat (60) @(negedge clk);
        chk(wr_n == 4, "R6 one burst per request", 32'(wr_n), 4);
        periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
        wait_idle(dur0);
        chk(wr_n == 8 && pk_n == 1, "R6 second burst completes", 32'(wr_n), 8);
        chk_writes(0, 8, 32'h2000, 4, 32'h9000, 0, "R5 fixed destination address");

        // R9: pause holds progress, resume completes
        put_desc(32'h500, mkcfg(2, 0, 0, 2, 0, 0), 32'h3000, 32'hA000, 120, 0, TERM);
        start_run(32'h500);
        while (wr_n < 5) @(negedge clk);
        reg_write(5'h04, 32'd1);
        repeat (5) @(negedge clk);
        snap = wr_n;
        reg_read(5'h18, v);
        repeat (50) @(negedge clk);
        reg_read(5'h18, v2);
        chk(wr_n == snap, "R9 no beats while paused", 32'(wr_n), 32'(snap));
        chk(v2 == v, "R9 bytes left held while paused", v2, v);
        reg_write(5'h04, 32'd0);
        wait_idle(dur0);
        chk(wr_n == 30, "R9 resume completes", 32'(wr_n), 30);
        chk_writes(0, 30, 32'h3000, 4, 32'hA000, 4, "R9 data after resume");

        // R10: halt
        start_run(32'h500);
        while (wr_n < 5) @(negedge clk);
        reg_write(5'h00, 32'd0);
        repeat (10) @(negedge clk);
        snap = wr_n;
        repeat (30) @(negedge clk);
        chk(wr_n == snap && wr_n < 30, "R10 beats stop after halt", 32'(wr_n), 32'(snap));
        chk(mem_req == 0, "R10 no request after halt", 32'(mem_req), 0);
        reg_read(5'h00, v);  chk(v == 0, "R10 enable reads zero", v, 0);

        // R8: two-descriptor chain, then a zero-byte descriptor
        put_desc(32'h600, mkcfg(2, 0, 0, 2, 0, 0), 32'h4000, 32'hB000, 8, 0, 32'h640);
        put_desc(32'h640, mkcfg(2, 1, 0, 1, 0, 0), 32'h5000, 32'hC000, 12, 32'h77, TERM);
        start_run(32'h600);
        wait_idle(dur0);
        chk(pk_n == 2, "R8 completion per descriptor", 32'(pk_n), 2);
        chk(wr_n == 5, "R8 chained beat count", 32'(wr_n), 5);
        chk(rd_n >= 10 && rd_addr[8] == 32'h640, "R8 link followed", rd_addr[8], 32'h640);
        chk_writes(0, 2, 32'h4000, 4, 32'hB000, 4, "R8 first descriptor data");
        chk_writes(2, 3, 32'h5000, 4, 32'hC000, 2, "R8 second descriptor data");
        reg_read(5'h1C, v);  chk(v == 32'h77, "R2 parameter readback", v, 32'h77);

        put_desc(32'h700, mkcfg(2, 0, 0, 2, 0, 0), 32'h6000, 32'hD000, 0, 0, TERM);
        start_run(32'h700);
        wait_idle(dur0);
        chk(wr_n == 0 && pk_n == 1, "R8 zero-byte descriptor", 32'(wr_n), 0);
    endtask

    initial begin
        fork
            main();
            begin
                repeat (190000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule